// File: doc/BRIEF.md
# Serial Receive Queue with Fill Trigger and Idle Timeout

This block buffers bytes coming out of a serial deserializer. Each accepted byte enters a 16-entry circular queue. Software drains the queue through a register read: the read port shows the oldest byte on `head_byte` and pulses `pop` to remove it. The fill level is always visible on `fill_count`.

A two-bit trigger select picks one of four fill thresholds. A byte that brings the fill to the threshold or above raises the ready flag `rx_ready`. A byte that leaves the fill below the threshold starts an idle timer instead. The timer runs for 15 character times, and one character time is `ETU_CYCLES` clock cycles. If no further byte restarts or cancels the timer before it runs out, the ready flag rises anyway, so a short trailing message is not left stranded in the queue. The interrupt request `rx_irq` is the ready flag gated by the interrupt enable.

The control inputs come from the serial port's register block: trigger select, a flush pulse, the interrupt enable and a flag-clear pulse. Bit-level reception, parity and framing checks belong to other blocks.

Top module: `uart_rxq`

## Requirements
- R1: Bytes leave in the order they arrived. `head_byte` shows the oldest stored byte whenever `fill_count` is non-zero. The storage indices wrap from entry `DEPTH-1` (15) back to entry 0 with no gap.
- R2: `trig_sel` sets the threshold: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14. Changing `trig_sel` alone does not change `rx_ready`.
- R3: A `fifo_flush` pulse sets `fill_count` to 0, clears `rx_ready`, cancels the idle timer and drops the next edge's `rx_irq`. It takes priority over a push or pop in the same cycle.
- R4: An accepted byte that brings the fill to the threshold or above sets `rx_ready` at that edge and cancels any running idle timer.
- R5: An accepted byte that leaves the fill below the threshold restarts the idle timer. If no later byte or flush intervenes, `rx_ready` rises exactly 15×`ETU_CYCLES` clock edges after the accepting edge.
- R6: A `pop` on a non-empty queue removes the head byte and lowers the fill by one. `rx_ready` clears at that edge if the remaining fill is below the threshold.
- R7: A byte offered while the queue holds `DEPTH` entries is dropped. The stored bytes and the fill do not change, even when a pop happens in the same cycle.
- R8: While `rx_enable` is low, `rx_valid` strobes are ignored.
- R9: With the queue empty, `head_byte` reads 8'h00, and a `pop` changes no state.
- R10: A push and a pop in the same cycle leave `fill_count` unchanged and keep byte order.
- R11: At each edge `rx_irq` takes the new value of `rx_ready` ANDed with `int_enable` as sampled at that edge.
- R12: `flag_clear` clears `rx_ready`, unless a set condition from R4 or R5 occurs in the same cycle; the set wins.
- R13: After synchronous reset, `fill_count` is 0, `rx_ready` and `rx_irq` are low, and the idle timer is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receive enable; strobes are ignored when low |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| trig_sel | input | 2 | Fill threshold select |
| fifo_flush | input | 1 | Pulse: empty the queue |
| int_enable | input | 1 | Receive interrupt enable |
| flag_clear | input | 1 | Pulse: clear the ready flag |
| pop | input | 1 | Pulse: the register read consumes the head byte |
| head_byte | output | 8 | Oldest stored byte, or 0 when empty |
| fill_count | output | 5 | Number of stored bytes |
| rx_ready | output | 1 | Receive-ready flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions check the following on every cycle: the fill never exceeds the depth, a flush always leaves the queue empty with the flag low, a full queue without a pop keeps its fill, a disabled receiver with no pop keeps its fill, a pop on an empty queue changes nothing, and the idle timer never exceeds its load value. Some behaviours need whole scenarios and are shown only by the bench. These are the FIFO ordering across a wrap, the exact edge on which the timeout raises the flag (including restarts), the threshold decoding, the set-over-clear priority and how the interrupt follows the enable.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Fill threshold selected by the two trigger-select bits.
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [WIDTH-1:0] rd_data
);

  // No reset on the array, so it maps onto distributed RAM.
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int ETU_CYCLES = 16,
  localparam int TICKS = 15 * ETU_CYCLES,
  localparam int TW = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic cancel,
  output logic expire
);

  logic [TW-1:0] cnt;

  // The final tick is reported unless the same cycle restarts or cancels the timer.
  assign expire = (cnt == TW'(1)) && !load && !cancel;

  always_ff @(posedge clk) begin
    if (rst || cancel)    cnt <= '0;
    else if (load)        cnt <= TW'(TICKS);
    else if (cnt != '0)   cnt <= cnt - TW'(1);
  end

  assert_timer_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= TW'(TICKS));

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq #(
  parameter int DEPTH = 16,
  parameter int ETU_CYCLES = 16,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_enable,
  input  logic            rx_valid,
  input  logic [7:0]      rx_byte,
  input  logic [1:0]      trig_sel,
  input  logic            fifo_flush,
  input  logic            int_enable,
  input  logic            flag_clear,
  input  logic            pop,
  output logic [7:0]      head_byte,
  output logic [CNTW-1:0] fill_count,
  output logic            rx_ready,
  output logic            rx_irq
);

  logic [IDXW-1:0] wr_idx, rd_idx;
  logic [CNTW-1:0] count, count_nxt, trig;
  logic            push_ok, pop_ok, at_trig, tmr_load, tmr_cancel, expire;
  logic            rdy_nxt;
  logic [7:0]      rd_data;

  assign trig    = CNTW'(rxq_pkg::trig_level(trig_sel));
  assign push_ok = rx_valid && rx_enable && (count != CNTW'(DEPTH)) && !fifo_flush;
  assign pop_ok  = pop && (count != '0) && !fifo_flush;

  always_comb begin
    if (fifo_flush) count_nxt = '0;
    else            count_nxt = count + CNTW'(push_ok) - CNTW'(pop_ok);
  end

  assign at_trig    = push_ok && (count_nxt >= trig);
  assign tmr_load   = push_ok && !at_trig;
  assign tmr_cancel = fifo_flush || at_trig;

  always_comb begin
    if (fifo_flush)                        rdy_nxt = 1'b0;
    else if (at_trig || expire)            rdy_nxt = 1'b1;
    else if (pop_ok && (count_nxt < trig)) rdy_nxt = 1'b0;
    else if (flag_clear)                   rdy_nxt = 1'b0;
    else                                   rdy_nxt = rx_ready;
  end

  always_ff @(posedge clk) begin
    if (rst || fifo_flush) begin
      wr_idx <= '0;
      rd_idx <= '0;
    end else begin
      if (push_ok) wr_idx <= (wr_idx == IDXW'(DEPTH - 1)) ? '0 : wr_idx + IDXW'(1);
      if (pop_ok)  rd_idx <= (rd_idx == IDXW'(DEPTH - 1)) ? '0 : rd_idx + IDXW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      rx_ready <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      count    <= count_nxt;
      rx_ready <= rdy_nxt;
      rx_irq   <= rdy_nxt && int_enable;
    end
  end

  rxq_store #(.DEPTH(DEPTH), .WIDTH(8)) u_store (
    .clk     (clk),
    .wr_en   (push_ok),
    .wr_idx  (wr_idx),
    .wr_data (rx_byte),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  rxq_timer #(.ETU_CYCLES(ETU_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .cancel (tmr_cancel),
    .expire (expire)
  );

  assign head_byte  = (count == '0) ? 8'h00 : rd_data;
  assign fill_count = count;

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    fill_count <= CNTW'(DEPTH));

  assert_flush_empties_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |=> (fill_count == '0) && !rx_ready);

  assert_full_discard_R7: assert property (@(posedge clk) disable iff (rst)
    (fill_count == CNTW'(DEPTH)) && !pop && !fifo_flush |=> fill_count == CNTW'(DEPTH));

  assert_disabled_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_enable && !pop && !fifo_flush |=> $stable(fill_count));

  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (rst)
    (fill_count == '0) && pop && !(rx_valid && rx_enable) |=> fill_count == '0);

endmodule

// File: tb/uart_rxq_bench.sv
`timescale 1ns/1ps
module uart_rxq_bench;

  localparam int ETU = 2;
  localparam int T   = 15 * ETU;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_enable = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [1:0] trig_sel = 2'b00;
  logic       fifo_flush = 1'b0, int_enable = 1'b0, flag_clear = 1'b0, pop = 1'b0;
  logic [7:0] head_byte;
  logic [4:0] fill_count;
  logic       rx_ready, rx_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_rxq #(.DEPTH(16), .ETU_CYCLES(ETU)) u_uart_rxq (
    .clk(clk), .rst(rst), .rx_enable(rx_enable), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .trig_sel(trig_sel), .fifo_flush(fifo_flush), .int_enable(int_enable),
    .flag_clear(flag_clear), .pop(pop), .head_byte(head_byte), .fill_count(fill_count),
    .rx_ready(rx_ready), .rx_irq(rx_irq)
  );

  // {en, valid, byte, pop, sel, flush, ie, clr, exp_head, exp_cnt, exp_flag, exp_irq}
  localparam int NV = 16;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0,1'b0,8'h00,1'b0,2'b01,1'b1,1'b1,1'b0, 8'h00,5'd0,1'b0,1'b0}, // R3 flush
    {1'b1,1'b1,8'hA1,1'b0,2'b01,1'b0,1'b1,1'b0, 8'h00,5'd1,1'b0,1'b0}, // R2 below 4
    {1'b1,1'b1,8'hA2,1'b0,2'b01,1'b0,1'b1,1'b0, 8'hA1,5'd2,1'b0,1'b0},
    {1'b1,1'b1,8'hA3,1'b0,2'b01,1'b0,1'b1,1'b0, 8'hA1,5'd3,1'b0,1'b0},
    {1'b1,1'b1,8'hA4,1'b0,2'b01,1'b0,1'b1,1'b0, 8'hA1,5'd4,1'b1,1'b1}, // R4 reach 4
    {1'b0,1'b0,8'h00,1'b1,2'b01,1'b0,1'b1,1'b0, 8'hA1,5'd3,1'b0,1'b0}, // R6 below
    {1'b1,1'b1,8'hA5,1'b1,2'b01,1'b0,1'b1,1'b0, 8'hA2,5'd3,1'b0,1'b0}, // R10
    {1'b0,1'b1,8'hA6,1'b0,2'b01,1'b0,1'b1,1'b0, 8'hA3,5'd3,1'b0,1'b0}, // R8
    {1'b1,1'b1,8'hA6,1'b0,2'b01,1'b0,1'b0,1'b0, 8'hA3,5'd4,1'b1,1'b0}, // R11 ie off
    {1'b0,1'b0,8'h00,1'b0,2'b01,1'b0,1'b1,1'b0, 8'hA3,5'd4,1'b1,1'b1}, // R11 ie on
    {1'b0,1'b0,8'h00,1'b0,2'b01,1'b0,1'b1,1'b1, 8'hA3,5'd4,1'b0,1'b0}, // R12 clear
    {1'b0,1'b0,8'h00,1'b1,2'b00,1'b0,1'b1,1'b0, 8'hA3,5'd3,1'b0,1'b0}, // R2 sel change
    {1'b1,1'b1,8'hA7,1'b0,2'b00,1'b0,1'b1,1'b1, 8'hA4,5'd4,1'b1,1'b1}, // R12 set wins
    {1'b0,1'b0,8'h00,1'b1,2'b00,1'b0,1'b1,1'b0, 8'hA4,5'd3,1'b1,1'b1}, // R6 stays
    {1'b1,1'b1,8'hA8,1'b1,2'b00,1'b1,1'b1,1'b0, 8'hA5,5'd0,1'b0,1'b0}, // R3 priority
    {1'b0,1'b0,8'h00,1'b1,2'b00,1'b0,1'b1,1'b0, 8'h00,5'd0,1'b0,1'b0}  // R9 empty pop
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] b);
    rx_enable = 1'b1; rx_valid = 1'b1; rx_byte = b;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic flush();
    fifo_flush = 1'b1;
    tick();
    fifo_flush = 1'b0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R13 reset state
    check("R13 count", fill_count, 0);
    check("R13 flag", rx_ready, 0);
    check("R13 irq", rx_irq, 0);
    check("R9 head empty", head_byte, 0);

    for (int i = 0; i < NV; i++) begin
      check($sformatf("vec%0d head R1", i), head_byte, VEC[i][14:7]);
      rx_enable  = VEC[i][30];
      rx_valid   = VEC[i][29];
      rx_byte    = VEC[i][28:21];
      pop        = VEC[i][20];
      trig_sel   = VEC[i][19:18];
      fifo_flush = VEC[i][17];
      int_enable = VEC[i][16];
      flag_clear = VEC[i][15];
      tick();
      check($sformatf("vec%0d count", i), fill_count, VEC[i][6:2]);
      check($sformatf("vec%0d flag", i), rx_ready, VEC[i][1]);
      check($sformatf("vec%0d irq R11", i), rx_irq, VEC[i][0]);
    end
    rx_valid = 0; pop = 0; fifo_flush = 0; flag_clear = 0;

    // R1 R7: fill to 16 with threshold 14, overflow, drain, wrap
    trig_sel = 2'b11; int_enable = 1'b0;
    flush();
    for (int i = 0; i < 16; i++) begin
      push(8'h10 + 8'(i));
      check("R1 fill count", fill_count, i + 1);
      check("R2 flag at 14", rx_ready, (i + 1) >= 14);
    end
    push(8'hEE);
    check("R7 full discard", fill_count, 16);
    pop = 1'b1; rx_valid = 1'b1; rx_byte = 8'hEF;
    tick();
    pop = 1'b0; rx_valid = 1'b0;
    check("R7 full push+pop", fill_count, 15);
    check("R7 order kept", head_byte, 8'h11);
    for (int i = 1; i < 16; i++) begin
      check("R1 order", head_byte, 8'h10 + 8'(i));
      pop = 1'b1;
      tick();
      pop = 1'b0;
      check("R6 drain count", fill_count, 15 - i);
      check("R6 drain flag", rx_ready, (15 - i) >= 14);
    end
    push(8'h5A);
    check("R1 wrap head", head_byte, 8'h5A);
    check("R1 wrap count", fill_count, 1);

    // R5 timeout below threshold
    trig_sel = 2'b01; int_enable = 1'b1;
    flush();
    push(8'h33);
    repeat (T - 1) tick();
    check("R5 before timeout", rx_ready, 0);
    tick();
    check("R5 timeout flag", rx_ready, 1);
    check("R5 timeout irq", rx_irq, 1);

    // R5 restart by a second byte
    flush();
    push(8'h44);
    repeat (10) tick();
    push(8'h45);
    repeat (T - 1) tick();
    check("R5 restart before", rx_ready, 0);
    tick();
    check("R5 restart flag", rx_ready, 1);
    check("R5 restart count", fill_count, 2);

    flush();
    check("R3 final flush", fill_count, 0);
    done = 1'b1;
    report();
  end

endmodule